// File: doc/BRIEF.md
# Dual Stack Pointer Unit

This unit keeps two 8-bit stack pointers over one nibble-addressed data memory. The nibble stack (pointer `sp2`) holds single 4-bit values: the A and B registers and the flag nibble. The wide stack (pointer `sp1`) holds 16-bit index values. Each of its entries fills four consecutive nibbles, so it is addressed at four times the pointer value.

The unit receives one operation code per clock. It drives the memory address, write data and strobes for that operation. For pops it also drives the write strobes and data for the destination registers. It owns the flag nibble. A flag pop reloads all four flags. Pointer increment and decrement refresh Z.

Memory reads are combinational. The pop data arrives on `rd_nib` or `rd_wide` in the same cycle the address is driven. Every operation completes in one clock.

Top module: `dual_stack_unit`

## Requirements
- R1: PUSH_A (1), PUSH_B (2) and PUSH_F (3) write `a_in`, `b_in` or the current flag nibble to nibble address `sp2-1` (mod 256), with `nib_we` high. After the edge `sp2` equals its old value minus 1.
- R2: POP_A (4), POP_B (5) and POP_F (6) drive `nib_re` high at nibble address `sp2`. They present `rd_nib` on `pop_nib`. POP_A raises `a_we` and POP_B raises `b_we`. After the edge `sp2` equals its old value plus 1.
- R3: PUSH_X (7) and PUSH_Y (8) drive `wide_we` high with base address `((sp1-1) mod 256)*4` and write data `x_in` or `y_in`. Bits 3..0 of the data belong at the base nibble and bits 15..12 at base+3. After the edge `sp1` is decremented by 1.
- R4: POP_X (9) and POP_Y (10) drive `wide_re` high with base address `sp1*4`. They present `rd_wide` on `pop_wide` and raise `x_we` or `y_we`. After the edge `sp1` is incremented by 1.
- R5: The flag nibble is {I,E,Z,C}: bit 3 is I, bit 2 is E, bit 1 is Z and bit 0 is C. POP_F loads all four flags from `rd_nib`. This holds even when `sp2` wraps to zero.
- R6: Every defined operation other than NOP and POP_F clears E. C and I are left unchanged, and so is Z except under R7.
- R7: INC_SP1 (11), DEC_SP1 (12), INC_SP2 (13) and DEC_SP2 (14) step the chosen pointer by one, wrapping mod 256. They set Z exactly when the new value is zero.
- R8: LD_SP1 (15) and LD_SP2 (16) copy `ba` into `sp1` or `sp2` in one clock.
- R9: After reset `sp1`, `sp2` and `flags` are zero.
- R10: NOP (0) and codes 17 to 31 leave the pointers and flags unchanged. They raise no memory or destination strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 5 | Operation code |
| ba | input | 8 | Load value for a pointer |
| a_in | input | 4 | A register value for push |
| b_in | input | 4 | B register value for push |
| x_in | input | 16 | X register value for push |
| y_in | input | 16 | Y register value for push |
| rd_nib | input | 4 | Nibble read data from memory |
| rd_wide | input | 16 | Four-nibble read data from memory |
| sp1 | output | 8 | Wide stack pointer |
| sp2 | output | 8 | Nibble stack pointer |
| flags | output | 4 | Flags {I,E,Z,C} |
| nib_addr | output | 8 | Nibble access address |
| nib_we | output | 1 | Nibble write strobe |
| nib_re | output | 1 | Nibble read strobe |
| nib_wdata | output | 4 | Nibble write data |
| wide_addr | output | 10 | Base nibble address of a wide access |
| wide_we | output | 1 | Wide write strobe |
| wide_re | output | 1 | Wide read strobe |
| wide_wdata | output | 16 | Wide write data |
| a_we | output | 1 | Load A from pop_nib |
| b_we | output | 1 | Load B from pop_nib |
| x_we | output | 1 | Load X from pop_wide |
| y_we | output | 1 | Load Y from pop_wide |
| pop_nib | output | 4 | Popped nibble |
| pop_wide | output | 16 | Popped wide value |

## Verification
A flag pop changes the nibble pointer and the whole flag nibble in the same cycle. The Z it loads from memory must win over any zero test of the new pointer. The bench provokes this with `sp2` at 0xFF and a stored nibble whose Z bit is clear, so the pop wraps the pointer to zero. It then expects Z to read back clear. E clearing likewise coincides with pointer stepping and Z updates, and the reference model judges it on every clock during a long random operation stream.

// File: rtl/dual_stack_unit.sv
module dual_stack_unit #(
  parameter int PW = 8,
  parameter int NW = 4,
  parameter int EN = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [4:0]                 op,
  input  logic [PW-1:0]              ba,
  input  logic [NW-1:0]              a_in,
  input  logic [NW-1:0]              b_in,
  input  logic [NW*EN-1:0]           x_in,
  input  logic [NW*EN-1:0]           y_in,
  input  logic [NW-1:0]              rd_nib,
  input  logic [NW*EN-1:0]           rd_wide,
  output logic [PW-1:0]              sp1,
  output logic [PW-1:0]              sp2,
  output logic [3:0]                 flags,
  output logic [PW-1:0]              nib_addr,
  output logic                       nib_we,
  output logic                       nib_re,
  output logic [NW-1:0]              nib_wdata,
  output logic [PW+$clog2(EN)-1:0]   wide_addr,
  output logic                       wide_we,
  output logic                       wide_re,
  output logic [NW*EN-1:0]           wide_wdata,
  output logic                       a_we,
  output logic                       b_we,
  output logic                       x_we,
  output logic                       y_we,
  output logic [NW-1:0]              pop_nib,
  output logic [NW*EN-1:0]           pop_wide
);
  localparam int SH = $clog2(EN);
  localparam int FZ = 1;
  localparam int FE = 2;

  localparam logic [4:0] NOP = 5'd0, PUSH_A = 5'd1, PUSH_B = 5'd2, PUSH_F = 5'd3;
  localparam logic [4:0] POP_A = 5'd4, POP_B = 5'd5, POP_F = 5'd6;
  localparam logic [4:0] PUSH_X = 5'd7, PUSH_Y = 5'd8, POP_X = 5'd9, POP_Y = 5'd10;
  localparam logic [4:0] INC_SP1 = 5'd11, DEC_SP1 = 5'd12, INC_SP2 = 5'd13, DEC_SP2 = 5'd14;
  localparam logic [4:0] LD_SP1 = 5'd15, LD_SP2 = 5'd16;

  logic [PW-1:0] sp1_up, sp1_dn, sp2_up, sp2_dn;
  logic          defined;

  assign sp1_up = sp1 + 1'b1;
  assign sp1_dn = sp1 - 1'b1;
  assign sp2_up = sp2 + 1'b1;
  assign sp2_dn = sp2 - 1'b1;
  assign defined = (op != NOP) && (op <= LD_SP2);

  assign nib_we    = (op == PUSH_A) || (op == PUSH_B) || (op == PUSH_F);
  assign nib_re    = (op == POP_A) || (op == POP_B) || (op == POP_F);
  assign nib_addr  = nib_we ? sp2_dn : sp2;
  assign nib_wdata = (op == PUSH_A) ? a_in : (op == PUSH_B) ? b_in : flags;

  assign wide_we    = (op == PUSH_X) || (op == PUSH_Y);
  assign wide_re    = (op == POP_X) || (op == POP_Y);
  assign wide_addr  = {(wide_we ? sp1_dn : sp1), {SH{1'b0}}};
  assign wide_wdata = (op == PUSH_Y) ? y_in : x_in;

  assign a_we     = (op == POP_A);
  assign b_we     = (op == POP_B);
  assign x_we     = (op == POP_X);
  assign y_we     = (op == POP_Y);
  assign pop_nib  = rd_nib;
  assign pop_wide = rd_wide;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp1   <= '0;
      sp2   <= '0;
      flags <= '0;
    end else begin
      if (defined && op != POP_F) flags[FE] <= 1'b0;
      case (op)
        PUSH_A, PUSH_B, PUSH_F: sp2 <= sp2_dn;
        POP_A, POP_B:           sp2 <= sp2_up;
        POP_F: begin
          sp2   <= sp2_up;
          flags <= rd_nib;
        end
        PUSH_X, PUSH_Y: sp1 <= sp1_dn;
        POP_X, POP_Y:   sp1 <= sp1_up;
        INC_SP1: begin sp1 <= sp1_up; flags[FZ] <= (sp1_up == '0); end
        DEC_SP1: begin sp1 <= sp1_dn; flags[FZ] <= (sp1_dn == '0); end
        INC_SP2: begin sp2 <= sp2_up; flags[FZ] <= (sp2_up == '0); end
        DEC_SP2: begin sp2 <= sp2_dn; flags[FZ] <= (sp2_dn == '0); end
        LD_SP1: sp1 <= ba;
        LD_SP2: sp2 <= ba;
        default: ;
      endcase
    end
  end

  p_nib_push_r1: assert property (@(posedge clk) disable iff (!rst_n)
    nib_we |=> sp2 == $past(nib_addr));
  p_nib_pop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    nib_re |=> sp2 == $past(sp2) + 1'b1);
  p_wide_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wide_we |=> {sp1, {SH{1'b0}}} == $past(wide_addr));
  p_wide_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wide_re |=> sp1 == $past(sp1) + 1'b1);
  p_flag_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == POP_F) |=> flags == $past(rd_nib));
  p_e_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (defined && op != POP_F) |=> !flags[FE]);
  p_z_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == INC_SP2 || op == DEC_SP2) |=> flags[FZ] == (sp2 == '0));
  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == LD_SP1) |=> sp1 == $past(ba));
  p_nop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !defined |=> $stable(sp1) && $stable(sp2) && $stable(flags));
  p_one_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({nib_we, nib_re, wide_we, wide_re, op == INC_SP1}));
endmodule

// File: tb/tb_dual_stack_unit.sv
module tb_dual_stack_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  op = '0;
  logic [7:0]  ba = '0;
  logic [3:0]  a_in = '0, b_in = '0;
  logic [15:0] x_in = '0, y_in = '0;
  logic [3:0]  rd_nib;
  logic [15:0] rd_wide;
  logic [7:0]  sp1, sp2, nib_addr;
  logic [3:0]  flags, nib_wdata, pop_nib;
  logic [9:0]  wide_addr;
  logic [15:0] wide_wdata, pop_wide;
  logic        nib_we, nib_re, wide_we, wide_re, a_we, b_we, x_we, y_we;

  logic [3:0] mem [1024];
  int checks = 0;
  int errors = 0;
  int m_sp1 = 0, m_sp2 = 0, m_fl = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_stack_unit dut (
    .clk(clk), .rst_n(rst_n), .op(op), .ba(ba), .a_in(a_in), .b_in(b_in),
    .x_in(x_in), .y_in(y_in), .rd_nib(rd_nib), .rd_wide(rd_wide),
    .sp1(sp1), .sp2(sp2), .flags(flags), .nib_addr(nib_addr), .nib_we(nib_we),
    .nib_re(nib_re), .nib_wdata(nib_wdata), .wide_addr(wide_addr), .wide_we(wide_we),
    .wide_re(wide_re), .wide_wdata(wide_wdata), .a_we(a_we), .b_we(b_we),
    .x_we(x_we), .y_we(y_we), .pop_nib(pop_nib), .pop_wide(pop_wide));

  always_comb begin
    rd_nib  = mem[{2'b00, nib_addr}];
    rd_wide = {mem[wide_addr + 10'd3], mem[wide_addr + 10'd2], mem[wide_addr + 10'd1], mem[wide_addr]};
  end

  always @(posedge clk) begin
    if (nib_we) mem[{2'b00, nib_addr}] <= nib_wdata;
    if (wide_we)
      for (int i = 0; i < 4; i++) mem[wide_addr + 10'(i)] <= wide_wdata[4*i +: 4];
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int o, input int b, input int a, input int bb, input int x, input int y);
    int e_nwe, e_nre, e_wwe, e_wre, e_naddr, e_waddr, e_nwd, e_wwd;
    int n_sp1, n_sp2, n_fl, rn, rw;
    string req;
    @(negedge clk);
    op = 5'(o); ba = 8'(b); a_in = 4'(a); b_in = 4'(bb); x_in = 16'(x); y_in = 16'(y);
    #1;
    e_nwe = (o >= 1 && o <= 3); e_nre = (o >= 4 && o <= 6);
    e_wwe = (o == 7 || o == 8); e_wre = (o == 9 || o == 10);
    e_naddr = e_nwe ? (m_sp2 + 255) % 256 : m_sp2;
    e_waddr = e_wwe ? ((m_sp1 + 255) % 256) * 4 : m_sp1 * 4;
    e_nwd = (o == 1) ? a : (o == 2) ? bb : m_fl;
    e_wwd = (o == 8) ? y : x;
    rn = mem[e_naddr];
    rw = {mem[e_waddr+3], mem[e_waddr+2], mem[e_waddr+1], mem[e_waddr]};
    req = (o == 0 || o > 16) ? "R10" : (o <= 3) ? "R1" : (o <= 6) ? "R2" :
          (o <= 8) ? "R3" : (o <= 10) ? "R4" : (o <= 14) ? "R7" : "R8";
    chk(req, "nib_we", int'(nib_we), e_nwe);
    chk(req, "nib_re", int'(nib_re), e_nre);
    chk(req, "wide_we", int'(wide_we), e_wwe);
    chk(req, "wide_re", int'(wide_re), e_wre);
    if (e_nwe || e_nre) chk(req, "nib_addr", int'(nib_addr), e_naddr);
    if (e_nwe) chk(req, "nib_wdata", int'(nib_wdata), e_nwd);
    if (e_wwe || e_wre) chk(req, "wide_addr", int'(wide_addr), e_waddr);
    if (e_wwe) chk(req, "wide_wdata", int'(wide_wdata), e_wwd);
    chk(req, "dest_we", int'({a_we, b_we, x_we, y_we}),
        {28'd0, o == 4, o == 5, o == 9, o == 10});
    if (e_nre) chk(req, "pop_nib", int'(pop_nib), rn);
    if (e_wre) chk(req, "pop_wide", int'(pop_wide), rw);
    n_sp1 = m_sp1; n_sp2 = m_sp2; n_fl = m_fl;
    if (o >= 1 && o <= 16 && o != 6) n_fl = n_fl & 4'b1011;
    case (o)
      1, 2, 3: n_sp2 = (m_sp2 + 255) % 256;
      4, 5:    n_sp2 = (m_sp2 + 1) % 256;
      6: begin n_sp2 = (m_sp2 + 1) % 256; n_fl = rn; end
      7, 8:    n_sp1 = (m_sp1 + 255) % 256;
      9, 10:   n_sp1 = (m_sp1 + 1) % 256;
      11: n_sp1 = (m_sp1 + 1) % 256;
      12: n_sp1 = (m_sp1 + 255) % 256;
      13: n_sp2 = (m_sp2 + 1) % 256;
      14: n_sp2 = (m_sp2 + 255) % 256;
      15: n_sp1 = b % 256;
      16: n_sp2 = b % 256;
      default: ;
    endcase
    if (o == 11 || o == 12) n_fl = (n_fl & 4'b1101) | ((n_sp1 == 0) ? 2 : 0);
    if (o == 13 || o == 14) n_fl = (n_fl & 4'b1101) | ((n_sp2 == 0) ? 2 : 0);
    m_sp1 = n_sp1; m_sp2 = n_sp2; m_fl = n_fl;
    @(posedge clk); #1;
    chk(req, "sp1", int'(sp1), m_sp1);
    chk(req, "sp2", int'(sp2), m_sp2);
    chk((o == 6) ? "R5" : "R6", "flags", int'(flags), m_fl);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog R1..: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 4'($urandom);
    repeat (3) @(posedge clk);
    #1;
    chk("R9", "sp1", int'(sp1), 0);
    chk("R9", "sp2", int'(sp2), 0);
    chk("R9", "flags", int'(flags), 0);
    @(negedge clk); rst_n = 1'b1;
    // R1/R2 nibble stack with wrap below zero
    step(1, 0, 5, 0, 0, 0);
    step(2, 0, 0, 10, 0, 0);
    step(3, 0, 0, 0, 0, 0);
    step(5, 0, 0, 0, 0, 0);
    step(4, 0, 0, 0, 0, 0);
    // R3/R4 wide stack wrap: base at 0x3FC
    step(7, 0, 0, 0, 16'hBEEF, 0);
    step(8, 0, 0, 0, 0, 16'h1234);
    step(10, 0, 0, 0, 0, 0);
    step(9, 0, 0, 0, 0, 0);
    // R7 wrap to zero sets Z, R6 clears E
    step(15, 8'hFF, 0, 0, 0, 0);
    step(11, 0, 0, 0, 0, 0);
    step(12, 0, 0, 0, 0, 0);
    // R5 coincidence: flag pop wraps sp2 to zero, stored Z clear
    mem[255] = 4'b1101;
    step(16, 8'hFF, 0, 0, 0, 0);
    step(6, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    step(23, 0, 0, 0, 0, 0);
    mem[255] = 4'b0110;
    step(16, 8'hFF, 0, 0, 0, 0);
    step(6, 0, 0, 0, 0, 0);
    step(14, 0, 0, 0, 0, 0);
    step(13, 0, 0, 0, 0, 0);
    for (int k = 0; k < 2000; k++)
      step($urandom_range(0, 20), $urandom_range(0, 255), $urandom_range(0, 15),
           $urandom_range(0, 15), $urandom_range(0, 65535), $urandom_range(0, 65535));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule